// File: doc/BRIEF.md
# CAN Error Confinement State Tracker

This block keeps the transmit and receive error counters of a CAN node and works out which fault-confinement state the node is in: error-active, error-passive or bus-off. The protocol engine sends it single-cycle event pulses. These mark a transmit error, a receive error, a successful transmission, a successful reception, and the end of the bus-off recovery sequence. Error detection itself is done elsewhere; this block only counts the events and classifies them.

The outputs are both counters, a status byte with warning, passive and bus-off indications, a two-bit state code, and a sticky error interrupt. The interrupt is set whenever the state code changes. The host clears it with a clear pulse, but the clear is refused while any status condition is still present. Reset is synchronous and active high.

Top module: `can_errconf`

## Requirements
- R1: While reset is high at a clock edge, both counters become 0, the status byte becomes 0x00, the state code becomes 0 and the interrupt becomes 0.
- R2: Outside bus-off, a transmit error adds 8 to the transmit counter. A successful transmission subtracts 1, and has no effect when the counter is 0. When both arrive in the same cycle, the error wins.
- R3: Outside bus-off, a receive error adds 1 to the receive counter, which holds at 255 instead of wrapping. A successful reception subtracts 1, and has no effect when the counter is 0. When both arrive in the same cycle, the error wins.
- R4: Status bit 2 is set when the transmit counter is 96 or more. Bit 1 is set when the receive counter is 96 or more. Bit 0 is the OR of bits 1 and 2. Bits 7 and 6 are always 0.
- R5: Status bit 4 is set when the transmit counter is above 127, and bit 3 when the receive counter is above 127. The state code is 1 (error-passive) when either of these holds outside bus-off. It returns to 0 (error-active) once both counters are at 127 or below.
- R6: A transmit error that would take the transmit counter past 255 loads 255 into it and enters bus-off. In bus-off, status bit 5 is 1 and the state code is 2.
- R7: In bus-off, error and success events have no effect on either counter. A recovery pulse in bus-off clears both counters and returns the state code to 0. A recovery pulse outside bus-off has no effect.
- R8: The interrupt output goes to 1 on the clock edge after any cycle in which the state code differs from its value in the previous cycle.
- R9: A clear pulse drops the interrupt at the next edge only if the status byte is 0x00 in that cycle and no state change is being flagged in the same cycle. Otherwise the interrupt stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txErrEv | input | 1 | Transmit error event pulse |
| rxErrEv | input | 1 | Receive error event pulse |
| txOkEv | input | 1 | Successful transmission pulse |
| rxOkEv | input | 1 | Successful reception pulse |
| recoverEv | input | 1 | Bus-off recovery complete pulse |
| intClear | input | 1 | Host request to clear the interrupt |
| txCount | output | 8 | Transmit error counter |
| rxCount | output | 8 | Receive error counter |
| errFlags | output | 8 | Status byte (bits 5..0 as in R4 to R6) |
| errState | output | 2 | 0 active, 1 passive, 2 bus-off |
| errIrq | output | 1 | Sticky error interrupt |

## Verification
The bench walks the transmit counter through 96, 128 and the overflow from 248. A design with an off-by-one threshold would flag warning or passive one error early or late. A design that wraps the counter would show a small count and no bus-off. It drives every event while in bus-off and expects the counters to stay frozen. It also fires recovery outside bus-off, where a careless design would clear the counters.

The receive counter is driven to 255 and beyond, to catch wrapping. Success events are applied at zero, to catch underflow. Error and success events are applied in the same cycle, to catch the wrong priority. Clear pulses are issued while a warning is still present, and in the same cycle as a state change. A design that clears unconditionally would drop the interrupt in those cycles.

// File: rtl/can_errconf_pkg.sv
package can_errconf_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_PASSIVE = 2'd1,
    ST_BUSOFF  = 2'd2
  } errState_e;

  typedef struct packed {
    logic txInc;
    logic txDec;
    logic rxInc;
    logic rxDec;
    logic recover;
  } ecStrobe_t;

endpackage

// File: rtl/can_errconf_dp.sv
module can_errconf_dp
  import can_errconf_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TX_STEP     = 8,
  parameter int RX_STEP     = 1,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  ecStrobe_t        strb,
  output logic [CNT_W-1:0] txCnt,
  output logic [CNT_W-1:0] rxCnt,
  output logic             busOff,
  output logic [7:0]       flags
);

  localparam logic [CNT_W:0]   MAX_X   = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W:0]   TXSTEPX = (CNT_W+1)'(TX_STEP);
  localparam logic [CNT_W:0]   RXSTEPX = (CNT_W+1)'(RX_STEP);
  localparam logic [CNT_W-1:0] WARN_V  = CNT_W'(WARN_LVL);
  localparam logic [CNT_W-1:0] PASS_V  = CNT_W'(PASSIVE_LVL);

  logic [CNT_W:0] txSum;
  logic [CNT_W:0] rxSum;

  always_comb begin
    txSum = {1'b0, txCnt} + TXSTEPX;
    rxSum = {1'b0, rxCnt} + RXSTEPX;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txCnt  <= '0;
      rxCnt  <= '0;
      busOff <= 1'b0;
    end else if (strb.recover) begin
      txCnt  <= '0;
      rxCnt  <= '0;
      busOff <= 1'b0;
    end else begin
      if (strb.txInc) begin
        if (txSum > MAX_X) begin
          txCnt  <= '1;
          busOff <= 1'b1;
        end else begin
          txCnt <= txSum[CNT_W-1:0];
        end
      end else if (strb.txDec && txCnt != '0) begin
        txCnt <= txCnt - 1'b1;
      end

      if (strb.rxInc) begin
        rxCnt <= (rxSum > MAX_X) ? '1 : rxSum[CNT_W-1:0];
      end else if (strb.rxDec && rxCnt != '0) begin
        rxCnt <= rxCnt - 1'b1;
      end
    end
  end

  always_comb begin
    flags    = 8'h00;
    flags[5] = busOff;
    flags[4] = txCnt > PASS_V;
    flags[3] = rxCnt > PASS_V;
    flags[2] = txCnt >= WARN_V;
    flags[1] = rxCnt >= WARN_V;
    flags[0] = flags[1] | flags[2];
  end

endmodule

// File: rtl/can_errconf_ctrl.sv
module can_errconf_ctrl
  import can_errconf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       txErrEv,
  input  logic       rxErrEv,
  input  logic       txOkEv,
  input  logic       rxOkEv,
  input  logic       recoverEv,
  input  logic       intClear,
  input  logic       busOff,
  input  logic [7:0] flags,
  output ecStrobe_t  strb,
  output errState_e  errState,
  output logic       errIrq
);

  errState_e stateLast;
  logic      stateMoved;

  always_comb begin
    strb.txInc   = txErrEv & ~busOff;
    strb.txDec   = txOkEv & ~txErrEv & ~busOff;
    strb.rxInc   = rxErrEv & ~busOff;
    strb.rxDec   = rxOkEv & ~rxErrEv & ~busOff;
    strb.recover = recoverEv & busOff;
  end

  always_comb begin
    if (busOff)                errState = ST_BUSOFF;
    else if (flags[4] | flags[3]) errState = ST_PASSIVE;
    else                       errState = ST_ACTIVE;
    stateMoved = (errState != stateLast);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateLast <= ST_ACTIVE;
      errIrq    <= 1'b0;
    end else begin
      stateLast <= errState;
      if (stateMoved)                      errIrq <= 1'b1;
      else if (intClear && flags == 8'h00) errIrq <= 1'b0;
    end
  end

endmodule

// File: rtl/can_errconf.sv
module can_errconf
  import can_errconf_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TX_STEP     = 8,
  parameter int RX_STEP     = 1,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txErrEv,
  input  logic             rxErrEv,
  input  logic             txOkEv,
  input  logic             rxOkEv,
  input  logic             recoverEv,
  input  logic             intClear,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic [7:0]       errFlags,
  output logic [1:0]       errState,
  output logic             errIrq
);

  ecStrobe_t strb;
  logic      busOff;
  errState_e stCode;

  can_errconf_dp #(
    .CNT_W(CNT_W), .TX_STEP(TX_STEP), .RX_STEP(RX_STEP),
    .WARN_LVL(WARN_LVL), .PASSIVE_LVL(PASSIVE_LVL)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .txCnt(txCount), .rxCnt(rxCount), .busOff(busOff), .flags(errFlags)
  );

  can_errconf_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .txErrEv(txErrEv), .rxErrEv(rxErrEv), .txOkEv(txOkEv), .rxOkEv(rxOkEv),
    .recoverEv(recoverEv), .intClear(intClear),
    .busOff(busOff), .flags(errFlags),
    .strb(strb), .errState(stCode), .errIrq(errIrq)
  );

  assign errState = stCode;

endmodule

// File: rtl/can_errconf_chk.sv
module can_errconf_chk (
  input logic       clk,
  input logic       rst,
  input logic       txErrEv,
  input logic       rxErrEv,
  input logic       recoverEv,
  input logic [7:0] txCount,
  input logic [7:0] rxCount,
  input logic [7:0] errFlags,
  input logic [1:0] errState,
  input logic       errIrq
);

  // R2: transmit error step below the overflow point
  p_tx_step_r2: assert property (@(posedge clk) disable iff (rst)
    (errState != 2'd2 && txErrEv && txCount < 8'd248) |=> txCount == $past(txCount) + 8'd8);

  // R3: receive counter saturates
  p_rx_sat_r3: assert property (@(posedge clk) disable iff (rst)
    (errState != 2'd2 && rxErrEv && rxCount == 8'hFF) |=> rxCount == 8'hFF);

  // R6: bus-off flag agrees with the state code
  p_busoff_code_r6: assert property (@(posedge clk) disable iff (rst)
    errFlags[5] == (errState == 2'd2));

  // R7: counters frozen in bus-off
  p_busoff_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (errState == 2'd2 && !recoverEv) |=> ($stable(txCount) && $stable(rxCount)));

  // R7: recovery clears everything
  p_recover_r7: assert property (@(posedge clk) disable iff (rst)
    (errState == 2'd2 && recoverEv) |=> (txCount == 8'd0 && rxCount == 8'd0 && errState == 2'd0));

  // R8: state change raises the interrupt
  p_irq_on_change_r8: assert property (@(posedge clk) disable iff (rst)
    (errState != $past(errState)) |=> errIrq);

  // R9: no clear while a condition stands
  p_clear_blocked_r9: assert property (@(posedge clk) disable iff (rst)
    (errIrq && errFlags != 8'h00) |=> errIrq);

endmodule

bind can_errconf can_errconf_chk u_chk (
  .clk(clk), .rst(rst), .txErrEv(txErrEv), .rxErrEv(rxErrEv),
  .recoverEv(recoverEv), .txCount(txCount), .rxCount(rxCount),
  .errFlags(errFlags), .errState(errState), .errIrq(errIrq)
);

// File: tb/can_errconf_tb.sv
module can_errconf_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txErrEv = 0, rxErrEv = 0, txOkEv = 0, rxOkEv = 0, recoverEv = 0, intClear = 0;
  logic [7:0] txCount, rxCount, errFlags;
  logic [1:0] errState;
  logic       errIrq;

  int  nChk = 0, nFail = 0;
  int  mTec = 0, mRec = 0, mLast = 0;
  bit  mBo = 0, mIrq = 0, done = 0;

  always #5 clk = ~clk;

  can_errconf u_dut (
    .clk(clk), .rst(rst), .txErrEv(txErrEv), .rxErrEv(rxErrEv),
    .txOkEv(txOkEv), .rxOkEv(rxOkEv), .recoverEv(recoverEv), .intClear(intClear),
    .txCount(txCount), .rxCount(rxCount), .errFlags(errFlags),
    .errState(errState), .errIrq(errIrq)
  );

  function automatic int stateOf(int t, int r, bit b);
    if (b) return 2;
    if (t > 127 || r > 127) return 1;
    return 0;
  endfunction

  function automatic int flagsOf(int t, int r, bit b);
    int f = 0;
    if (b)       f |= 32;
    if (t > 127) f |= 16;
    if (r > 127) f |= 8;
    if (t >= 96) f |= 4;
    if (r >= 96) f |= 2;
    if (t >= 96 || r >= 96) f |= 1;
    return f;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    check(txCount == mTec[7:0], "R2 txCount", txCount, mTec);
    check(rxCount == mRec[7:0], "R3 rxCount", rxCount, mRec);
    check(errFlags == 8'(flagsOf(mTec, mRec, mBo)), "R4 errFlags", errFlags, flagsOf(mTec, mRec, mBo));
    check(errState == 2'(stateOf(mTec, mRec, mBo)), "R5 errState", errState, stateOf(mTec, mRec, mBo));
    check(errIrq == mIrq, "R8 errIrq", errIrq, mIrq);
  endtask

  task automatic step(input bit te, input bit re, input bit to, input bit ro,
                      input bit rc, input bit clr);
    int st, fl;
    @(negedge clk);
    txErrEv = te; rxErrEv = re; txOkEv = to; rxOkEv = ro; recoverEv = rc; intClear = clr;
    st = stateOf(mTec, mRec, mBo);
    fl = flagsOf(mTec, mRec, mBo);
    if (st != mLast)          mIrq = 1;
    else if (clr && fl == 0)  mIrq = 0;
    mLast = st;
    if (mBo) begin
      if (rc) begin mTec = 0; mRec = 0; mBo = 0; end
    end else begin
      if (te) begin
        if (mTec + 8 > 255) begin mTec = 255; mBo = 1; end
        else mTec += 8;
      end else if (to && mTec > 0) mTec--;
      if (re) begin
        if (mRec < 255) mRec++;
      end else if (ro && mRec > 0) mRec--;
    end
    @(posedge clk);
    #2;
    checkAll();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst = 1;
    repeat (3) @(posedge clk);
    #2;
    check(txCount == 0 && rxCount == 0, "R1 counters", {txCount, rxCount}, 0);
    check(errFlags == 0 && errState == 0 && errIrq == 0, "R1 status", {errFlags, errState, errIrq}, 0);
    @(negedge clk);
    rst = 0;

    // R2: success at zero does not underflow
    step(0, 0, 1, 1, 0, 0);
    check(txCount == 0, "R2 floor", txCount, 0);
    // R4: warning at 96
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0, 0);
    check(errFlags == 8'h05, "R4 warn", errFlags, 5);
    // R5: passive at 128, error beats success
    for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0, 0);
    check(errState == 2'd1 && txCount == 128, "R5 passive", errState, 1);
    idle();
    check(errIrq == 1, "R8 raise", errIrq, 1);
    // R9: clear refused while flags stand
    step(0, 0, 0, 0, 0, 1);
    check(errIrq == 1, "R9 blocked", errIrq, 1);
    // R7: recovery outside bus-off ignored
    step(0, 0, 0, 0, 1, 0);
    check(txCount == 128, "R7 idle recover", txCount, 128);
    // R6: overflow past 255
    for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 0);
    check(errState == 2'd2 && txCount == 255, "R6 busoff", txCount, 255);
    // R7: frozen in bus-off
    for (int i = 0; i < 6; i++) step(1, 1, 1, 1, 0, 1);
    check(txCount == 255 && rxCount == 0, "R7 hold", txCount, 255);
    step(0, 0, 0, 0, 1, 0);
    check(txCount == 0 && errState == 0, "R7 recover", errState, 0);
    // R9: clear in the change cycle loses, later clear wins
    step(0, 0, 0, 0, 0, 1);
    check(errIrq == 1, "R9 set wins", errIrq, 1);
    step(0, 0, 0, 0, 0, 1);
    check(errIrq == 0, "R9 cleared", errIrq, 0);
    // R3: receive saturation
    for (int i = 0; i < 300; i++) step(0, 1, 0, 1, 0, 0);
    check(rxCount == 255, "R3 saturate", rxCount, 255);
    step(0, 0, 0, 1, 0, 0);
    check(rxCount == 254, "R3 decrement", rxCount, 254);

    for (int i = 0; i < 3000; i++) begin
      int rw = (i < 1500) ? 15 : 45;
      step(($urandom % 100) < 6, ($urandom % 100) < rw, ($urandom % 100) < 30,
           ($urandom % 100) < 30, ($urandom % 100) < 3, ($urandom % 100) < 10);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule